// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor that completes one whole instruction in every clock cycle. The instruction is fetched, decoded, its register operands read, an addition or comparison done, data memory optionally touched and the result written back, all before the next rising edge. It runs six operations: register-register add, add with immediate, word load, word store, branch when two registers are equal, and an unconditional jump that stays inside the current 256 MB region.

The core holds its own word-wide instruction memory, which the environment fills while reset is held. It also holds a data memory, a register file with two read ports and one write port, an adder-based ALU, sign extension and a control decoder that drives the datapath multiplexers. The only ports are clock, a synchronous reset, and taps that show the current program counter and the register write made in the current cycle.

Top module: `scc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, every register becomes 0 and the data memory becomes 0. No register or memory write happens in a cycle where `rst` is high.
- R2: Instructions use opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, bits 10:6 as a shift field, funct in 5:0, a 16-bit immediate in 15:0 and a 26-bit jump target in 25:0. Opcode 0x00 with funct 0x20 and a zero shift field writes rs+rt (modulo 2^32) into rd, and the PC advances by 4.
- R3: Opcode 0x08 writes rs plus the sign-extended immediate into rt, and the PC advances by 4.
- R4: Opcode 0x23 forms the address rs + sign-extended immediate and writes the data-memory word at that address into rt. Address bits 1:0 are ignored, and the word index wraps modulo the data-memory depth.
- R5: Opcode 0x2B writes rt into the data-memory word addressed as in R4 at the rising edge. It writes no register, and a later load returns the stored value.
- R6: Opcode 0x04 writes no register. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4.
- R7: Opcode 0x02 writes no register and sets the PC to {PC[31:28], target[25:0], 2'b00}.
- R8: Register 0 reads as zero, and a write aimed at it is dropped. `dbg_rf_we` never rises with `dbg_rf_waddr` equal to 0.
- R9: Any other encoding writes no register and no memory, and advances the PC by 4. This includes opcode 0x00 with a funct other than 0x20 or a nonzero shift field.
- R10: Register reads are combinational and register and memory writes land at the rising edge. An instruction therefore sees every result of the instruction before it.
- R11: `dbg_pc` shows the address of the instruction executing this cycle. The instruction is fetched from word index PC[..:2] modulo the instruction-memory depth. `dbg_rf_we`, `dbg_rf_waddr` and `dbg_rf_wdata` show the register write that lands at the coming edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_rf_we | output | 1 | A register write lands at the coming edge |
| dbg_rf_waddr | output | 5 | Destination register of that write |
| dbg_rf_wdata | output | 32 | Value being written |

## Verification
The interesting overlap is a write-back and the operand read of the next instruction. A result written at one edge must already be the operand that the following instruction adds, compares, stores or uses as a base address. A store followed by a load of the same word is the memory form of the same overlap. The overlap is provoked with dependent chains and with random programs drawn from registers r0 to r7 only, so almost every instruction reads something written one or two cycles earlier. A bench-side instruction-level model judges each cycle by comparing the PC and the register write with the model's own arithmetic.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef logic [31:0] word_t;
  typedef logic [4:0]  ridx_t;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_J     = 6'h02;
  localparam logic [5:0] FN_ADD    = 6'h20;

  typedef enum logic [1:0] {NPC_SEQ, NPC_BRANCH, NPC_JUMP} npc_sel_e;
  typedef enum logic {ALU_ADD, ALU_SUB} alu_op_e;
  typedef enum logic {WB_ALU, WB_MEM} wb_sel_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;
    logic    alu_imm;
    alu_op_e alu_op;
    wb_sel_e wb_sel;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump;
    logic    illegal;
  } ctrl_t;

  function automatic word_t sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic word_t seq_pc(input word_t pc);
    return pc + 32'd4;
  endfunction

  function automatic word_t branch_pc(input word_t pc, input logic [15:0] off);
    word_t s;
    s = sext16(off);
    return pc + 32'd4 + (s << 2);
  endfunction

  function automatic word_t jump_pc(input word_t pc, input logic [25:0] tgt);
    return {pc[31:28], tgt, 2'b00};
  endfunction

  function automatic word_t alu_eval(input word_t a, input word_t b, input alu_op_e op);
    return (op == ALU_SUB) ? (a - b) : (a + b);
  endfunction

endpackage

// File: rtl/scc_imem.sv
module scc_imem
  import scc_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic [AW-1:0] idx,
  output word_t         data
);
  // Contents are filled from outside while the core is held in reset.
  word_t mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  assign data = mem[idx];
endmodule

// File: rtl/scc_dmem.sv
module scc_dmem
  import scc_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  word_t         wdata,
  output word_t         rdata
);
  word_t mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = re ? mem[idx] : '0;
endmodule

// File: rtl/scc_regfile.sv
module scc_regfile
  import scc_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  localparam int unsigned RW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  word_t         wdata,
  input  logic [RW-1:0] raddr_a,
  input  logic [RW-1:0] raddr_b,
  output word_t         rdata_a,
  output word_t         rdata_b
);
  word_t regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  // Register zero is hard-wired; reads never see stored state.
  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/scc_alu.sv
module scc_alu
  import scc_pkg::*;
(
  input  word_t   a,
  input  word_t   b,
  input  alu_op_e op,
  output word_t   y,
  output logic    zero
);
  assign y    = alu_eval(a, b, op);
  assign zero = (y == '0);
endmodule

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{reg_write: 1'b0, dst_rd: 1'b0, alu_imm: 1'b0, alu_op: ALU_ADD,
            wb_sel: WB_ALU, mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0,
            jump: 1'b0, illegal: 1'b0};
    unique case (opc)
      OPC_RTYPE: begin
        if (funct == FN_ADD && shamt == '0) begin
          ctl.reg_write = 1'b1;
          ctl.dst_rd    = 1'b1;
        end else begin
          ctl.illegal = 1'b1;
        end
      end
      OPC_ADDI: begin
        ctl.reg_write = 1'b1;
        ctl.alu_imm   = 1'b1;
      end
      OPC_LW: begin
        ctl.reg_write = 1'b1;
        ctl.alu_imm   = 1'b1;
        ctl.mem_read  = 1'b1;
        ctl.wb_sel    = WB_MEM;
      end
      OPC_SW: begin
        ctl.alu_imm   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OPC_J: begin
        ctl.jump = 1'b1;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/scc_pc.sv
module scc_pc
  import scc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        branch,
  input  logic        jump,
  input  logic        alu_zero,
  input  logic [15:0] imm16,
  input  logic [25:0] tgt26,
  output word_t       pc,
  output logic        br_taken
);
  npc_sel_e sel;
  word_t    npc;

  always_comb begin
    br_taken = branch & alu_zero;
    if (jump)          sel = NPC_JUMP;
    else if (br_taken) sel = NPC_BRANCH;
    else               sel = NPC_SEQ;
    unique case (sel)
      NPC_JUMP:   npc = jump_pc(pc, tgt26);
      NPC_BRANCH: npc = branch_pc(pc, imm16);
      default:    npc = seq_pc(pc);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= npc;
  end
endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_rf_we,
  output logic [4:0]  dbg_rf_waddr,
  output logic [31:0] dbg_rf_wdata
);
  localparam int unsigned IAW = $clog2(IMEM_WORDS);
  localparam int unsigned DAW = $clog2(DMEM_WORDS);

  word_t pc, instr, rs_val, rt_val, imm_ext, alu_b, alu_y, dm_rdata, wb_data;
  ctrl_t ctl;
  logic  alu_zero;
  ridx_t waddr;

  // Named events observed by the bound checker.
  logic ev_branch_taken, ev_jump, ev_illegal, ev_dmem_we, ev_rf_we;

  scc_imem #(.WORDS(IMEM_WORDS)) u_imem (
    .idx  (pc[IAW+1:2]),
    .data (instr)
  );

  scc_ctrl u_ctrl (
    .opc   (instr[31:26]),
    .shamt (instr[10:6]),
    .funct (instr[5:0]),
    .ctl   (ctl)
  );

  assign waddr      = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign ev_rf_we   = ctl.reg_write & ~rst & (waddr != '0);
  assign ev_dmem_we = ctl.mem_write & ~rst;
  assign ev_jump    = ctl.jump;
  assign ev_illegal = ctl.illegal;

  scc_regfile #(.NREGS(32)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ev_rf_we),
    .waddr   (waddr),
    .wdata   (wb_data),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign imm_ext = sext16(instr[15:0]);
  assign alu_b   = ctl.alu_imm ? imm_ext : rt_val;

  scc_alu u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  scc_dmem #(.WORDS(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .rst   (rst),
    .we    (ev_dmem_we),
    .re    (ctl.mem_read),
    .idx   (alu_y[DAW+1:2]),
    .wdata (rt_val),
    .rdata (dm_rdata)
  );

  assign wb_data = (ctl.wb_sel == WB_MEM) ? dm_rdata : alu_y;

  scc_pc u_pc (
    .clk      (clk),
    .rst      (rst),
    .branch   (ctl.branch),
    .jump     (ctl.jump),
    .alu_zero (alu_zero),
    .imm16    (instr[15:0]),
    .tgt26    (instr[25:0]),
    .pc       (pc),
    .br_taken (ev_branch_taken)
  );

  assign dbg_pc       = pc;
  assign dbg_rf_we    = ev_rf_we;
  assign dbg_rf_waddr = waddr;
  assign dbg_rf_wdata = wb_data;
endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        br_taken,
  input logic        jmp,
  input logic        illegal,
  input logic        dm_we
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> (pc == 32'h0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we));

  // R8
  no_r0_write_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr != 5'd0));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rf_we && !dm_we));

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_taken && !jmp) |=> (pc == $past(pc) + 32'd4));

  // R6
  branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc == $past(pc) + 32'd4 +
                  {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  // R7
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    jmp |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

  // R9
  excl_flow_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({br_taken, jmp, illegal}));
endmodule

bind scc_core scc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (dbg_pc),
  .instr    (instr),
  .rf_we    (dbg_rf_we),
  .rf_waddr (dbg_rf_waddr),
  .br_taken (ev_branch_taken),
  .jmp      (ev_jump),
  .illegal  (ev_illegal),
  .dm_we    (ev_dmem_we)
);

// File: tb/scc_core_tb.sv
`timescale 1ns/1ps
module scc_core_tb;
  localparam int IMEM_WORDS = 64;
  localparam int DMEM_WORDS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_rf_wdata;
  logic        dbg_rf_we;
  logic [4:0]  dbg_rf_waddr;

  always #2 clk = ~clk;

  scc_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_dut (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_rf_we(dbg_rf_we),
    .dbg_rf_waddr(dbg_rf_waddr), .dbg_rf_wdata(dbg_rf_wdata)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] prog  [IMEM_WORDS];
  logic [31:0] mregs [32];
  logic [31:0] mdm   [DMEM_WORDS];
  logic [31:0] mpc;
  logic [31:0] seed = 32'h1ACE_B00C;
  string       pre = "";

  function automatic logic [31:0] enc_add(int rs, int rt, int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'h02, tgt[25:0]};
  endfunction

  task automatic rnd(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic report(string tag, string what, logic [31:0] act, logic [31:0] exp);
    miscompares++;
    $display("FAIL %s%s %s actual=%h expected=%h (pc=%h)", pre, tag, what, act, exp, mpc);
  endtask

  // Loads the program, holds reset and checks the reset state (R1).
  task automatic start_prog();
    rst = 1'b1;
    for (int i = 0; i < IMEM_WORDS; i++) u_dut.u_imem.mem[i] = prog[i];
    for (int i = 0; i < 32; i++) mregs[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) mdm[i] = '0;
    mpc = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    vectors++;
    if (dbg_pc !== 32'h0) report("R1", "reset pc", dbg_pc, 32'h0);
    if (dbg_rf_we !== 1'b0) report("R1", "write during reset", {31'd0, dbg_rf_we}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One cycle: compare taps with the model, then advance the model.
  task automatic step();
    logic [31:0] ins, simm, ea, nxt, ed;
    logic [5:0]  op;
    int          rs, rt, rd;
    logic        ewe;
    int          ea_i;
    string       tag;
    #1;
    ins  = prog[(mpc >> 2) & (IMEM_WORDS - 1)];
    op   = ins[31:26];
    rs   = ins[25:21];
    rt   = ins[20:16];
    rd   = ins[15:11];
    simm = {{16{ins[15]}}, ins[15:0]};
    nxt  = mpc + 32'd4;
    ewe  = 1'b0;
    ea_i = 0;
    ed   = '0;
    tag  = "R9";
    ea   = mregs[rs] + simm;
    if (op == 6'h00 && ins[5:0] == 6'h20 && ins[10:6] == 5'd0) begin
      tag = "R2"; ea_i = rd; ed = mregs[rs] + mregs[rt]; ewe = (rd != 0);
    end else if (op == 6'h08) begin
      tag = "R3"; ea_i = rt; ed = mregs[rs] + simm; ewe = (rt != 0);
    end else if (op == 6'h23) begin
      tag = "R4"; ea_i = rt; ed = mdm[(ea >> 2) & (DMEM_WORDS - 1)]; ewe = (rt != 0);
    end else if (op == 6'h2B) begin
      tag = "R5"; // memory effect is judged by later loads (R4/R5)
      mdm[(ea >> 2) & (DMEM_WORDS - 1)] = mregs[rt];
    end else if (op == 6'h04) begin
      tag = "R6";
      if (mregs[rs] == mregs[rt]) nxt = mpc + 32'd4 + (simm << 2);
    end else if (op == 6'h02) begin
      tag = "R7"; nxt = {mpc[31:28], ins[25:0], 2'b00};
    end
    if (ewe == 1'b0 && (op == 6'h00 || op == 6'h08 || op == 6'h23) && tag != "R9")
      tag = "R8";
    vectors++;
    if (dbg_pc !== mpc) report("R11", {tag, " pc"}, dbg_pc, mpc);
    if (dbg_rf_we !== ewe) report(tag, "write enable", {31'd0, dbg_rf_we}, {31'd0, ewe});
    else if (ewe) begin
      if (dbg_rf_waddr !== ea_i[4:0]) report(tag, "write addr", {27'd0, dbg_rf_waddr}, ea_i);
      if (dbg_rf_wdata !== ed) report(tag, "write data", dbg_rf_wdata, ed);
    end
    if (ewe) mregs[ea_i] = ed;
    mpc = nxt;
    @(negedge clk);
  endtask

  task automatic gen_prog();
    logic [31:0] r, a, b, c, d;
    for (int i = 0; i < IMEM_WORDS; i++) begin
      rnd(r); rnd(a); rnd(b); rnd(c); rnd(d);
      case (r % 16)
        0, 1, 2, 3: prog[i] = enc_add(a % 8, b % 8, c % 8);
        4, 5, 6:    prog[i] = enc_i(6'h08, a % 8, b % 8, int'(d % 32) - 16);
        7, 8:       prog[i] = enc_i(6'h23, a % 8, b % 8, int'(d % 64) - 24);
        9, 10:      prog[i] = enc_i(6'h2B, a % 8, b % 8, int'(d % 64) - 24);
        11, 12:     prog[i] = enc_i(6'h04, a % 8, b % 8, int'(d % 9) - 4);
        13:         prog[i] = enc_j((d[3]) ? int'(d % 64) : int'(d[25:0]));
        14:         prog[i] = {6'h00, a[4:0], b[4:0], c[4:0], d[4:0], d[9] ? 6'h22 : 6'h20} |
                              (d[9] ? 32'h0 : 32'h40);
        default:    prog[i] = {d[0] ? 6'h3F : 6'h0D, a[4:0], b[4:0], d[15:0]};
      endcase
    end
  endtask

  initial begin
    // Directed dependent chain: every operand comes from the previous write (R10).
    for (int i = 0; i < IMEM_WORDS; i++) prog[i] = '0;
    prog[0]  = enc_add(1, 2, 3);
    prog[1]  = enc_i(6'h08, 0, 1, 5);
    prog[2]  = enc_i(6'h08, 1, 2, -3);
    prog[3]  = enc_add(1, 2, 3);
    prog[4]  = enc_i(6'h2B, 0, 3, 10);
    prog[5]  = enc_i(6'h23, 0, 4, 8);
    prog[6]  = enc_i(6'h08, 0, 0, 9);
    prog[7]  = enc_add(0, 4, 5);
    prog[8]  = enc_i(6'h04, 4, 3, 1);
    prog[9]  = enc_i(6'h08, 0, 6, 1);
    prog[10] = enc_j(12);
    prog[11] = enc_i(6'h08, 0, 6, 2);
    prog[12] = 32'hFC00_0000;
    prog[13] = enc_i(6'h04, 1, 2, -14);
    prog[14] = enc_j(0);
    pre = "R10 ";
    start_prog();
    for (int k = 0; k < 40; k++) step();
    // A second run after reset must start from cleared registers (R1).
    pre = "R1 ";
    start_prog();
    for (int k = 0; k < 8; k++) step();
    pre = "";
    for (int p = 0; p < 30; p++) begin
      gen_prog();
      start_prog();
      for (int k = 0; k < 150; k++) step();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule